// File: doc/BRIEF.md
# Exclusive Access Monitor

This block tracks load-exclusive / store-exclusive pairs issued by several processors and decides, for every exclusive store, whether the write may reach memory. Each processor has its own request stream carrying a physical address, a shared-region attribute bit and an operation code. Accesses marked non-shared use a per-processor "reservation pending" flag. Accesses marked shared use a per-processor word-address tag. Each processor holds at most one tag, and a newer exclusive load replaces it.

At most one request is accepted per cycle. When several processors request in the same cycle, the lowest-numbered one wins. Every other requester sees `req_ready` low and must hold its request until it is accepted; a request is taken only on a cycle where valid and ready are both high. One cycle after acceptance the block presents a registered response: the processor number, a pass/fail status and the write-enable bound for memory. The response has no ready; the consumer must take it in the cycle it is shown. The memory, its data path and any address translation sit outside this block.

Top module: `excl_monitor`

## Requirements
- R1: While `rst` is high on a clock edge, all flags and tags are cleared, and after that edge `resp_valid` and `mem_we` are low. An exclusive store issued right after reset fails, whether shared or not.
- R2: `req_ready` has at most one bit set, and that bit is the lowest-indexed set bit of `req_valid`. A request that is not granted gets no response and must be held.
- R3: A request accepted at a clock edge produces `resp_valid`=1 and `resp_cpu` = its processor number after the next edge. `resp_valid` is 0 after an edge with no acceptance.
- R4: Op code 0 (exclusive load) with `req_shared`=1 sets that processor's tag to the request's word address. Any earlier tag of that processor is replaced. The response has status 0 and `mem_we`=0.
- R5: Op code 0 with `req_shared`=0 sets that processor's pending flag and leaves its tag unchanged. The response has status 0 and `mem_we`=0.
- R6: Op code 1 (exclusive store) with `req_shared`=0 passes only if the processor's pending flag is set. A pass gives status 0 and `mem_we`=1 and clears the flag. A fail gives status 1 and `mem_we`=0.
- R7: Op code 1 with `req_shared`=1 passes only if the processor holds a valid tag equal to the request's word address. A pass gives status 0 and `mem_we`=1 and clears the tag. Any other case, including an address that differs from the last exclusive load, gives status 1 and `mem_we`=0.
- R8: Address bits [1:0] are ignored in every tag compare and tag write.
- R9: A performed write with `req_shared`=1 clears the matching tag of every other processor. A performed write is an op 2 store or a passing op 1. Failed exclusive stores and non-shared writes clear no other processor's tag.
- R10: Op code 2 (ordinary store) always gives `mem_we`=1 and status 0. It leaves the requester's own tag and flag unchanged.
- R11: Op code 3 (reserved) is accepted, changes no state, and gives status 1 and `mem_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_CPU | Request valid, one bit per processor |
| req_ready | output | NUM_CPU | Request accepted, one-hot or zero |
| req_addr | input | NUM_CPU*ADDR_W | Physical byte address, ADDR_W bits per processor |
| req_shared | input | NUM_CPU | Shared-region attribute per processor |
| req_op | input | 2*NUM_CPU | Op code per processor: 0 excl load, 1 excl store, 2 store, 3 reserved |
| resp_valid | output | 1 | Response valid |
| resp_cpu | output | $clog2(NUM_CPU) | Processor number of the response |
| resp_status | output | 1 | 0 = success, 1 = failed exclusive store or reserved op |
| mem_we | output | 1 | Write enable toward memory for this response |

## Verification
The pass/fail decision is driven with matched load/store pairs and with stores that have no reservation, so a monitor that always passes is told apart from one that tracks state. The same store is issued twice and a second load is made to a different word, which separates tag clearing and tag replacement from sticky tags. Another processor writes to a tagged word in four ways: shared, non-shared, by a failed store and by a passing store. These show whether cross-processor invalidation is tied to the attribute and to a performed write. Simultaneous requests from two processors check the priority order and that the losing request is held and then served.

// File: rtl/excl_pkg.sv
package excl_pkg;
  typedef enum logic [1:0] {
    OP_LDEX = 2'd0,
    OP_STEX = 2'd1,
    OP_ST   = 2'd2,
    OP_RSVD = 2'd3
  } excl_op_e;
endpackage

// File: rtl/excl_arb.sv
// Fixed-priority grant: lowest index wins.
module excl_arb #(
  parameter int NUM_CPU = 4,
  localparam int IDW = $clog2(NUM_CPU)
) (
  input  logic [NUM_CPU-1:0] req,
  output logic [NUM_CPU-1:0] gnt,
  output logic [IDW-1:0]     gnt_id,
  output logic               gnt_any
);
  localparam logic [NUM_CPU-1:0] ONE = {{(NUM_CPU-1){1'b0}}, 1'b1};

  assign gnt     = req & (~req + ONE);
  assign gnt_any = |req;

  always_comb begin
    gnt_id = '0;
    for (int i = NUM_CPU - 1; i >= 0; i--) begin
      if (req[i]) gnt_id = IDW'(i);
    end
  end
endmodule

// File: rtl/excl_tag_bank.sv
// Per-processor reservation state and pass/fail decision.
module excl_tag_bank
  import excl_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int WA_W    = 30,
  localparam int IDW = $clog2(NUM_CPU)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc,
  input  logic [IDW-1:0]  cpu,
  input  logic [WA_W-1:0] waddr,
  input  logic            shared,
  input  excl_op_e        op,
  output logic            pass,
  output logic            write
);
  logic [NUM_CPU-1:0] hit;
  logic [NUM_CPU-1:0] loc_flag;

  always_comb begin
    pass = 1'b0;
    if (op == OP_STEX) pass = shared ? hit[cpu] : loc_flag[cpu];
    write = (op == OP_ST) || pass;
  end

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
    logic            vld;
    logic            loc;
    logic [WA_W-1:0] taddr;
    logic            mine;

    assign hit[g]      = vld && (taddr == waddr);
    assign loc_flag[g] = loc;
    assign mine        = (cpu == IDW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        vld   <= 1'b0;
        loc   <= 1'b0;
        taddr <= '0;
      end else if (acc) begin
        if (mine) begin
          if (op == OP_LDEX) begin
            if (shared) begin
              vld   <= 1'b1;
              taddr <= waddr;
            end else begin
              loc <= 1'b1;
            end
          end else if (op == OP_STEX && pass) begin
            if (shared) vld <= 1'b0;
            else        loc <= 1'b0;
          end
        end else if (write && shared && hit[g]) begin
          vld <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 32,
  localparam int IDW  = $clog2(NUM_CPU),
  localparam int WA_W = ADDR_W - 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_CPU-1:0]        req_valid,
  output logic [NUM_CPU-1:0]        req_ready,
  input  logic [NUM_CPU*ADDR_W-1:0] req_addr,
  input  logic [NUM_CPU-1:0]        req_shared,
  input  logic [2*NUM_CPU-1:0]      req_op,
  output logic                      resp_valid,
  output logic [IDW-1:0]            resp_cpu,
  output logic                      resp_status,
  output logic                      mem_we
);
  logic [IDW-1:0]    gid;
  logic              acc;
  logic [ADDR_W-1:0] sel_addr;
  logic              sel_sh;
  excl_op_e          sel_op;
  logic              pass;
  logic              write;
  logic              fail;

  excl_arb #(.NUM_CPU(NUM_CPU)) u_arb (
    .req    (req_valid),
    .gnt    (req_ready),
    .gnt_id (gid),
    .gnt_any(acc)
  );

  always_comb begin
    sel_addr = req_addr[gid*ADDR_W +: ADDR_W];
    sel_sh   = req_shared[gid];
    sel_op   = excl_op_e'(req_op[gid*2 +: 2]);
  end

  excl_tag_bank #(.NUM_CPU(NUM_CPU), .WA_W(WA_W)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .acc   (acc),
    .cpu   (gid),
    .waddr (sel_addr[ADDR_W-1:2]),
    .shared(sel_sh),
    .op    (sel_op),
    .pass  (pass),
    .write (write)
  );

  assign fail = ((sel_op == OP_STEX) && !pass) || (sel_op == OP_RSVD);

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid  <= 1'b0;
      resp_cpu    <= '0;
      resp_status <= 1'b0;
      mem_we      <= 1'b0;
    end else begin
      resp_valid  <= acc;
      resp_status <= acc && fail;
      mem_we      <= acc && write;
      if (acc) resp_cpu <= gid;
    end
  end
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int NUM_CPU = 4,
  parameter int IDW     = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_CPU-1:0]   req_valid,
  input logic [NUM_CPU-1:0]   req_ready,
  input logic [2*NUM_CPU-1:0] req_op,
  input logic                 resp_valid,
  input logic [IDW-1:0]       resp_cpu,
  input logic                 resp_status,
  input logic                 mem_we
);
  logic [IDW-1:0] gidx;
  logic [1:0]     gop;
  logic           hs;

  always_comb begin
    gidx = '0;
    for (int i = 0; i < NUM_CPU; i++) begin
      if (req_ready[i]) gidx = IDW'(i);
    end
    gop = req_op[gidx*2 +: 2];
    hs  = |req_ready;
  end

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !resp_valid && !mem_we);
  a_r2_ready_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(req_ready));
  a_r2_ready_subset: assert property (@(posedge clk) disable iff (rst) (req_ready & ~req_valid) == '0);
  a_r2_ready_some: assert property (@(posedge clk) disable iff (rst) (|req_valid) |-> hs);
  a_r3_resp_after_hs: assert property (@(posedge clk) disable iff (rst) hs |=> resp_valid);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst) !hs |=> !resp_valid);
  a_r3_resp_cpu: assert property (@(posedge clk) disable iff (rst) hs |=> resp_cpu == $past(gidx));
  a_r4_load_quiet: assert property (@(posedge clk) disable iff (rst) (hs && gop == 2'd0) |=> !mem_we && !resp_status);
  a_r10_store_writes: assert property (@(posedge clk) disable iff (rst) (hs && gop == 2'd2) |=> mem_we && !resp_status);
  a_r11_reserved: assert property (@(posedge clk) disable iff (rst) (hs && gop == 2'd3) |=> !mem_we && resp_status);
  a_r6_we_status: assert property (@(posedge clk) disable iff (rst) mem_we |-> resp_valid && !resp_status);
endmodule

bind excl_monitor excl_monitor_chk #(.NUM_CPU(NUM_CPU), .IDW(IDW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_op     (req_op),
  .resp_valid (resp_valid),
  .resp_cpu   (resp_cpu),
  .resp_status(resp_status),
  .mem_we     (mem_we)
);

// File: tb/excl_monitor_bench.sv
module excl_monitor_bench;
  localparam int N  = 4;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  req_valid;
  logic [N-1:0]  req_ready;
  logic [N*AW-1:0] req_addr;
  logic [N-1:0]  req_shared;
  logic [2*N-1:0] req_op;
  logic          resp_valid;
  logic [1:0]    resp_cpu;
  logic          resp_status;
  logic          mem_we;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  excl_monitor #(.NUM_CPU(N), .ADDR_W(AW)) u_excl_monitor (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_shared(req_shared), .req_op(req_op),
    .resp_valid(resp_valid), .resp_cpu(resp_cpu), .resp_status(resp_status),
    .mem_we(mem_we)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input int c, input logic [31:0] a, input logic sh, input logic [1:0] op);
    req_valid[c] = 1'b1;
    req_addr[c*AW +: AW] = a;
    req_shared[c] = sh;
    req_op[c*2 +: 2] = op;
  endtask

  // one request, checks grant and the response one cycle later
  task automatic one(input string req, input int c, input logic [31:0] a, input logic sh,
                     input logic [1:0] op, input logic st, input logic we);
    @(negedge clk);
    drive(c, a, sh, op);
    #1 check({req, " ready"}, 32'(req_ready), 32'(1 << c));
    @(negedge clk);
    req_valid = '0;
    check({req, " valid"}, 32'(resp_valid), 1);
    check({req, " cpu"}, 32'(resp_cpu), 32'(c));
    check({req, " status"}, 32'(resp_status), 32'(st));
    check({req, " we"}, 32'(mem_we), 32'(we));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 resp_valid", 32'(resp_valid), 0);
    check("R1 mem_we", 32'(mem_we), 0);
    one("R1 stex local", 0, 32'h40, 1'b0, 2'd1, 1'b1, 1'b0);
    one("R1 stex shared", 0, 32'h40, 1'b1, 2'd1, 1'b1, 1'b0);
    @(negedge clk);
    check("R3 idle", 32'(resp_valid), 0);
  endtask

  task automatic t_local;
    one("R5 ldex local", 0, 32'h10, 1'b0, 2'd0, 1'b0, 1'b0);
    one("R6 stex pass", 0, 32'h10, 1'b0, 2'd1, 1'b0, 1'b1);
    one("R6 stex again", 0, 32'h10, 1'b0, 2'd1, 1'b1, 1'b0);
    one("R5 local no tag", 1, 32'h20, 1'b0, 2'd0, 1'b0, 1'b0);
    one("R5 shared miss", 1, 32'h20, 1'b1, 2'd1, 1'b1, 1'b0);
  endtask

  task automatic t_shared;
    one("R4 ldex shared", 1, 32'h100, 1'b1, 2'd0, 1'b0, 1'b0);
    one("R7 wrong word", 1, 32'h104, 1'b1, 2'd1, 1'b1, 1'b0);
    one("R8 low bits", 1, 32'h102, 1'b1, 2'd1, 1'b0, 1'b1);
    one("R7 cleared", 1, 32'h100, 1'b1, 2'd1, 1'b1, 1'b0);
  endtask

  task automatic t_replace;
    one("R4 first", 2, 32'h200, 1'b1, 2'd0, 1'b0, 1'b0);
    one("R4 second", 2, 32'h303, 1'b1, 2'd0, 1'b0, 1'b0);
    one("R4 old gone", 2, 32'h200, 1'b1, 2'd1, 1'b1, 1'b0);
    one("R4 new held", 2, 32'h300, 1'b1, 2'd1, 1'b0, 1'b1);
  endtask

  task automatic t_snoop;
    one("R9 a0", 0, 32'h400, 1'b1, 2'd0, 1'b0, 1'b0);
    one("R9 a1", 1, 32'h400, 1'b1, 2'd0, 1'b0, 1'b0);
    one("R10 st shared", 2, 32'h401, 1'b1, 2'd2, 1'b0, 1'b1);
    one("R9 c0 lost", 0, 32'h400, 1'b1, 2'd1, 1'b1, 1'b0);
    one("R9 c1 lost", 1, 32'h400, 1'b1, 2'd1, 1'b1, 1'b0);
    one("R9 b0", 0, 32'h500, 1'b1, 2'd0, 1'b0, 1'b0);
    one("R9 b1", 1, 32'h500, 1'b1, 2'd0, 1'b0, 1'b0);
    one("R9 b3 fail", 3, 32'h500, 1'b1, 2'd1, 1'b1, 1'b0);
    one("R9 b1 pass", 1, 32'h500, 1'b1, 2'd1, 1'b0, 1'b1);
    one("R9 b0 lost", 0, 32'h500, 1'b1, 2'd1, 1'b1, 1'b0);
    one("R9 n0", 0, 32'h600, 1'b1, 2'd0, 1'b0, 1'b0);
    one("R9 nonshared st", 3, 32'h600, 1'b0, 2'd2, 1'b0, 1'b1);
    one("R9 n0 kept", 0, 32'h600, 1'b1, 2'd1, 1'b0, 1'b1);
  endtask

  task automatic t_own_store;
    one("R10 o2 ld", 2, 32'h700, 1'b1, 2'd0, 1'b0, 1'b0);
    one("R10 o2 st", 2, 32'h700, 1'b1, 2'd2, 1'b0, 1'b1);
    one("R10 o2 kept", 2, 32'h700, 1'b1, 2'd1, 1'b0, 1'b1);
    one("R10 o3 ld", 3, 32'h710, 1'b0, 2'd0, 1'b0, 1'b0);
    one("R10 o3 st", 3, 32'h710, 1'b0, 2'd2, 1'b0, 1'b1);
    one("R10 o3 kept", 3, 32'h710, 1'b0, 2'd1, 1'b0, 1'b1);
  endtask

  task automatic t_reserved;
    one("R11 r1 ld", 1, 32'h800, 1'b1, 2'd0, 1'b0, 1'b0);
    one("R11 r0 ld", 0, 32'h800, 1'b0, 2'd0, 1'b0, 1'b0);
    one("R11 rsvd", 2, 32'h800, 1'b1, 2'd3, 1'b1, 1'b0);
    one("R11 own rsvd", 1, 32'h900, 1'b1, 2'd3, 1'b1, 1'b0);
    one("R11 r1 kept", 1, 32'h800, 1'b1, 2'd1, 1'b0, 1'b1);
    one("R11 r0 kept", 0, 32'h800, 1'b0, 2'd1, 1'b0, 1'b1);
  endtask

  task automatic t_collide;
    @(negedge clk);
    drive(1, 32'hA00, 1'b1, 2'd0);
    drive(3, 32'hA00, 1'b1, 2'd0);
    #1 check("R2 lowest first", 32'(req_ready), 32'h2);
    @(negedge clk);
    req_valid[1] = 1'b0;
    check("R3 first cpu", 32'(resp_cpu), 1);
    check("R3 first valid", 32'(resp_valid), 1);
    #1 check("R2 held then granted", 32'(req_ready), 32'h8);
    @(negedge clk);
    req_valid = '0;
    check("R3 second cpu", 32'(resp_cpu), 3);
    check("R3 second valid", 32'(resp_valid), 1);
    one("R2 c1 tag", 1, 32'hA00, 1'b1, 2'd1, 1'b0, 1'b1);
    one("R2 c3 lost", 3, 32'hA00, 1'b1, 2'd1, 1'b1, 1'b0);
  endtask

  initial begin
    req_valid = '0;
    req_addr = '0;
    req_shared = '0;
    req_op = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_local();
    t_shared();
    t_replace();
    t_snoop();
    t_own_store();
    t_reserved();
    t_collide();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule